// File: doc/BRIEF.md
# Zero-Register Stack Processor Sequencer

This block is the control core of a tiny 8-bit processor that has no general registers. It holds three pieces of state: an instruction pointer, a stack pointer and a carry flag. Every operand comes from a stack held in memory, and that stack grows toward lower addresses. Program, data and stack all share one 256-byte memory. The core reaches that memory through a single synchronous port, and read data returns one cycle after the address is presented.

Each instruction is one byte. Small immediates, operand distances and stack offsets are packed into the opcode itself. The core runs a fixed sequence of states for every instruction: fetch, decode, up to two operand reads, then one write-back (two for the exchange). To jump, a program pushes the target address and moves it into the instruction pointer. Reading the pointers and relocating the stack also go through the stack. All pointer and address arithmetic wraps modulo 256.

Top module: `stack_core`

## Requirements
- R1: After reset IP=0x00, SP=0x00 and CF=0. The first fetch is from address 0x00 and the first push writes address 0xFF.
- R2: IP advances by one when an opcode is fetched. 0xE2 pushes the address of the instruction that follows it. 0xE3 pops the top byte into IP.
- R3: An opcode in 0x00-0x7F, or in 0xF0-0xFF, decrements SP and writes the opcode byte itself to the new top.
- R4: Opcodes 0x80-0xAF, excluding the undefined codes 0x88-0x8F and 0x9C-0x9F, are two-operand ops. Bits [1:0] give SIZE=1<<bits. A is the top byte and B is the byte at SP+SIZE. 0x80-0x83 write B+A+CF with CF as the carry out. 0x84-0x87 write B-A-CF with CF as the borrow. The result goes to SP+SIZE and SP then increments.
- R5: 0xA0-0xA3 (OR), 0xA4-0xA7 (AND), 0xA8-0xAB (XOR) and 0xAC-0xAF (always 0x00) set CF exactly when the result is zero.
- R6: 0x90-0x93 leaves A at SP+SIZE when CF=1 and leaves B there otherwise, then pops, with CF unchanged. 0x94-0x97 exchange A and B without changing SP or CF.
- R7: 0x98-0x9B store B rotated left by A mod 8 at SP+SIZE, clear CF and pop.
- R8: The one-operand ops replace the top byte and keep SP unchanged: 0xB0 adds one, 0xB1 subtracts one and 0xB2 negates, all with CF unchanged. 0xB4 shifts left with CF in at bit 0 and bit 7 out to CF. 0xB5 shifts right with CF in at bit 7 and bit 0 out to CF. 0xB6 inverts and 0xB7 passes the byte through; both set CF exactly when the result is zero.
- R9: 0xC0-0xCF (offset N in bits [3:0]) push a copy of the byte at SP+N, using the SP from before the push. 0xD0-0xDF write the top byte to SP+N+1 and then pop.
- R10: 0xE0 replaces the top byte with memory[top]. 0xE1 writes the byte at SP+1 to memory[top] and then adds 2 to SP.
- R11: 0xE4 pushes the SP value held before the instruction. 0xE5 sets SP to the top byte.
- R12: 0xE8 clears CF, 0xE9 sets it and 0xEA inverts it. 0xEF adds one to SP. 0xEE and every undefined opcode change no state.
- R13: Writes happen only in the decode cycle of a push and in write-back cycles, never during a fetch or an operand read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read data, valid one cycle after its address |

## Verification
The pointers and the carry flag can only be observed through the memory port. A wrong SP shows up as a result written one or more bytes away from where it belongs, so the write address of the same instruction or the next one is already off. A wrong IP sends the next fetch to the wrong byte, and the corrupted values then appear in the stack image within a few instructions. A wrong CF stays hidden until an operation consumes it, so the programs end with a conditional select that turns the flag into a stored 0 or 1.

// File: rtl/stack_core.sv
module stack_core (
  input  logic       clk,
  input  logic       rst_n,
  output logic [7:0] mem_addr,
  output logic [7:0] mem_wdata,
  output logic       mem_we,
  input  logic [7:0] mem_rdata
);

  typedef enum logic [2:0] {S_FETCH, S_DEC, S_RD1, S_RD2, S_EXE, S_WR2} state_t;

  state_t     state;
  logic [7:0] ip, sp, ir, opa, opb;
  logic       cf;

  logic [7:0] op;
  assign op = (state == S_DEC) ? mem_rdata : ir;

  logic is_push, is_add, is_sub, is_iff, is_swp, is_rot, is_log, is_bin, is_un;
  logic is_ldo, is_sto, is_lda, is_sta, is_ldi, is_sti, is_lds, is_sts;
  logic is_clc, is_sec, is_flc, is_pop, needs_mem;

  assign is_push = ~op[7] | (op[7:4] == 4'hF);
  assign is_add  = op[7:2] == 6'b100000;
  assign is_sub  = op[7:2] == 6'b100001;
  assign is_iff  = op[7:2] == 6'b100100;
  assign is_swp  = op[7:2] == 6'b100101;
  assign is_rot  = op[7:2] == 6'b100110;
  assign is_log  = op[7:4] == 4'hA;
  assign is_bin  = is_add | is_sub | is_iff | is_swp | is_rot | is_log;
  assign is_un   = (op[7:3] == 5'b10110) && (op[2:0] != 3'd3);
  assign is_ldo  = op[7:4] == 4'hC;
  assign is_sto  = op[7:4] == 4'hD;
  assign is_lda  = op == 8'hE0;
  assign is_sta  = op == 8'hE1;
  assign is_ldi  = op == 8'hE2;
  assign is_sti  = op == 8'hE3;
  assign is_lds  = op == 8'hE4;
  assign is_sts  = op == 8'hE5;
  assign is_clc  = op == 8'hE8;
  assign is_sec  = op == 8'hE9;
  assign is_flc  = op == 8'hEA;
  assign is_pop  = op == 8'hEF;
  assign needs_mem = is_bin | is_un | is_ldo | is_sto | is_lda | is_sta | is_sti | is_sts;

  logic [7:0] size, ofs;
  assign size = 8'd1 << op[1:0];
  assign ofs  = {4'd0, op[3:0]};

  logic [7:0]  alu_res;
  logic        alu_cf;
  logic [8:0]  wide;
  logic [15:0] rot2;

  always_comb begin
    alu_res = mem_rdata;
    alu_cf  = cf;
    wide    = '0;
    rot2    = {mem_rdata, mem_rdata} << opa[2:0];
    if (is_add) begin
      wide = {1'b0, mem_rdata} + {1'b0, opa} + {8'd0, cf};
      {alu_cf, alu_res} = wide;
    end else if (is_sub) begin
      wide = {1'b0, mem_rdata} - {1'b0, opa} - {8'd0, cf};
      {alu_cf, alu_res} = wide;
    end else if (is_iff) begin
      alu_res = cf ? opa : mem_rdata;
    end else if (is_swp) begin
      alu_res = opa;
    end else if (is_rot) begin
      alu_res = rot2[15:8];
      alu_cf  = 1'b0;
    end else if (is_log) begin
      case (op[3:2])
        2'd0:    alu_res = opa | mem_rdata;
        2'd1:    alu_res = opa & mem_rdata;
        2'd2:    alu_res = opa ^ mem_rdata;
        default: alu_res = 8'h00;
      endcase
      alu_cf = (alu_res == 8'h00);
    end else if (is_un) begin
      case (op[2:0])
        3'd0: alu_res = opa + 8'd1;
        3'd1: alu_res = opa - 8'd1;
        3'd2: alu_res = 8'd0 - opa;
        3'd4: begin alu_res = {opa[6:0], cf}; alu_cf = opa[7]; end
        3'd5: begin alu_res = {cf, opa[7:1]}; alu_cf = opa[0]; end
        3'd6: begin alu_res = ~opa; alu_cf = (opa == 8'hFF); end
        default: begin alu_res = opa; alu_cf = (opa == 8'h00); end
      endcase
    end
  end

  always_comb begin
    mem_addr  = ip;
    mem_wdata = 8'h00;
    mem_we    = 1'b0;
    case (state)
      S_DEC: begin
        if (is_push | is_ldi | is_lds) begin
          mem_addr  = sp - 8'd1;
          mem_we    = 1'b1;
          mem_wdata = is_ldi ? ip + 8'd1 : (is_lds ? sp : mem_rdata);
        end
      end
      S_RD1: mem_addr = is_ldo ? sp + ofs : sp;
      S_RD2: begin
        if (is_bin)      mem_addr = sp + size;
        else if (is_sta) mem_addr = sp + 8'd1;
        else if (is_lda) mem_addr = mem_rdata;
        else             mem_addr = sp;
      end
      S_EXE: begin
        if (is_bin) begin
          mem_addr = sp + size; mem_wdata = alu_res; mem_we = 1'b1;
        end else if (is_un) begin
          mem_addr = sp; mem_wdata = alu_res; mem_we = 1'b1;
        end else if (is_ldo) begin
          mem_addr = sp - 8'd1; mem_wdata = opa; mem_we = 1'b1;
        end else if (is_sto) begin
          mem_addr = sp + ofs + 8'd1; mem_wdata = opa; mem_we = 1'b1;
        end else if (is_lda) begin
          mem_addr = sp; mem_wdata = mem_rdata; mem_we = 1'b1;
        end else if (is_sta) begin
          mem_addr = opa; mem_wdata = mem_rdata; mem_we = 1'b1;
        end
      end
      S_WR2: begin
        mem_addr = sp; mem_wdata = opb; mem_we = 1'b1;
      end
      default: mem_addr = ip;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_FETCH;
      ip    <= 8'h00;
      sp    <= 8'h00;
      cf    <= 1'b0;
      ir    <= 8'h00;
      opa   <= 8'h00;
      opb   <= 8'h00;
    end else begin
      case (state)
        S_FETCH: state <= S_DEC;
        S_DEC: begin
          ir <= mem_rdata;
          ip <= ip + 8'd1;
          if (is_push | is_ldi | is_lds) sp <= sp - 8'd1;
          if (is_pop) sp <= sp + 8'd1;
          if (is_clc) cf <= 1'b0;
          if (is_sec) cf <= 1'b1;
          if (is_flc) cf <= ~cf;
          state <= needs_mem ? S_RD1 : S_FETCH;
        end
        S_RD1: state <= S_RD2;
        S_RD2: begin
          opa   <= mem_rdata;
          state <= S_EXE;
        end
        S_EXE: begin
          opb   <= mem_rdata;
          state <= S_FETCH;
          if (is_bin) begin
            cf <= alu_cf;
            if (is_swp) state <= S_WR2;
            else        sp <= sp + 8'd1;
          end
          if (is_un)  cf <= alu_cf;
          if (is_ldo) sp <= sp - 8'd1;
          if (is_sto) sp <= sp + 8'd1;
          if (is_sta) sp <= sp + 8'd2;
          if (is_sti) begin ip <= opa; sp <= sp + 8'd1; end
          if (is_sts) sp <= opa;
        end
        default: state <= S_FETCH;
      endcase
    end
  end

  AST_IP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DEC) |=> (ip == $past(ip) + 8'd1)); // R2
  AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DEC && mem_we) |=> (sp == $past(mem_addr))); // R3
  AST_BIN_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EXE && is_bin && !is_swp) |=> (sp == $past(sp) + 8'd1)); // R4
  AST_SWP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EXE && is_swp) |=> (state == S_WR2 && $stable(sp) && $stable(cf))); // R6
  AST_ROT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EXE && is_rot) |=> !cf); // R7
  AST_NO_READ_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FETCH || state == S_RD1 || state == S_RD2) |-> !mem_we); // R13

endmodule

// File: tb/stack_core_tb_top.sv
`timescale 1ns/1ps
module stack_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic       mem_we;
  logic       ld_en = 1'b0;
  logic [7:0] ld_addr = 8'h00, ld_data = 8'h00;
  logic [7:0] mem [256];
  logic [7:0] img [256];
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  stack_core dut_i (.clk(clk), .rst_n(rst_n), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata));

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  int plen;
  task automatic clear_img();
    for (int i = 0; i < 256; i++) img[i] = 8'h00;
    plen = 0;
  endtask

  task automatic put(input logic [7:0] b);
    img[plen] = b;
    plen++;
  endtask

  task automatic run(input bit chk_reset);
    img[plen]   = plen[7:0];
    img[plen+1] = 8'hE3;
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = i[7:0]; ld_data = img[i];
    end
    @(negedge clk);
    ld_en = 1'b0;
    if (chk_reset) begin
      check("R1 reset fetch addr", mem_addr, 8'h00);
      check("R1 reset no write", {7'd0, mem_we}, 8'h00);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (250) @(negedge clk);
  endtask

  function automatic logic [8:0] model(input logic [7:0] o, input logic [7:0] a,
                                       input logic [7:0] b, input logic c);
    logic [8:0] w;
    logic [7:0] r;
    logic [15:0] t;
    case (o)
      8'h80: w = {1'b0, b} + {1'b0, a} + {8'd0, c};
      8'h84: w = {1'b0, b} - {1'b0, a} - {8'd0, c};
      8'h90: w = {c, c ? a : b};
      8'h98: begin t = {b, b} << a[2:0]; w = {1'b0, t[15:8]}; end
      8'hA0: begin r = a | b; w = {r == 8'h00, r}; end
      8'hA4: begin r = a & b; w = {r == 8'h00, r}; end
      8'hA8: begin r = a ^ b; w = {r == 8'h00, r}; end
      8'hAC: w = {1'b1, 8'h00};
      8'hB0: w = {c, a + 8'd1};
      8'hB1: w = {c, a - 8'd1};
      8'hB2: w = {c, 8'd0 - a};
      8'hB4: w = {a[7], a[6:0], c};
      8'hB5: w = {a[0], c, a[7:1]};
      8'hB6: begin r = ~a; w = {r == 8'h00, r}; end
      default: w = {a == 8'h00, a};
    endcase
    return w;
  endfunction

  function automatic string tag(input logic [7:0] o);
    if (o == 8'h80 || o == 8'h84) return "R4";
    if (o == 8'h90) return "R6";
    if (o == 8'h98) return "R7";
    if (o[7:4] == 4'hA) return "R5";
    return "R8";
  endfunction

  function automatic logic [7:0] mkv(input logic [31:0] r);
    return r[7] ? {4'hF, r[3:0]} : {1'b0, r[6:0]};
  endfunction

  logic [7:0] ops [15] = '{8'h80, 8'h84, 8'h90, 8'h98, 8'hA0, 8'hA4, 8'hA8, 8'hAC,
                           8'hB0, 8'hB1, 8'hB2, 8'hB4, 8'hB5, 8'hB6, 8'hB7};

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R13 watchdog expired: actual hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));

    clear_img(); put(8'h05); put(8'hF3);
    run(1'b1);
    check("R1 first push at FF", mem[8'hFF], 8'h05);
    check("R3 negative push", mem[8'hFE], 8'hF3);

    clear_img(); put(8'hE8); put(8'h40); put(8'h01); put(8'h02); put(8'h03); put(8'h0F); put(8'hAA);
    run(1'b0);
    check("R4 size 4 result", mem[8'hFF], 8'h4F);
    check("R4 size 4 untouched", mem[8'hFE], 8'h01);

    clear_img(); put(8'hE9); put(8'hF0); put(8'hFF); put(8'h80); put(8'h00); put(8'h01); put(8'h90);
    run(1'b0);
    check("R4 add with carry", mem[8'hFF], 8'hF0);
    check("R4 carry out", mem[8'hFE], 8'h01);

    clear_img(); put(8'h11); put(8'h22); put(8'h33); put(8'h95);
    run(1'b0);
    check("R6 swap far", mem[8'hFF], 8'h33);
    check("R6 swap middle", mem[8'hFE], 8'h22);
    check("R6 swap top", mem[8'hFD], 8'h11);

    clear_img(); put(8'hE8); put(8'h11); put(8'h22); put(8'h90);
    run(1'b0);
    check("R6 select keeps B", mem[8'hFF], 8'h11);

    clear_img(); put(8'h10); put(8'h20); put(8'h30); put(8'hC1); put(8'hD2);
    run(1'b0);
    check("R9 load offset then store offset", mem[8'hFF], 8'h20);
    check("R9 middle kept", mem[8'hFE], 8'h20);

    clear_img(); put(8'h44); put(8'h70); put(8'hE1); put(8'h70); put(8'hE0);
    run(1'b0);
    check("R10 store to address", mem[8'h70], 8'h44);
    check("R10 load from address", mem[8'hFF], 8'h44);

    clear_img(); put(8'hE2); put(8'hE4); put(8'h60); put(8'hE5); put(8'h0A);
    run(1'b0);
    check("R2 ip push", mem[8'hFF], 8'h01);
    check("R11 sp push", mem[8'hFE], 8'hFF);
    check("R11 sp load", mem[8'h5F], 8'h0A);

    clear_img(); put(8'h04); put(8'hE3); put(8'h33); put(8'h33); put(8'h22);
    run(1'b0);
    check("R2 jump", mem[8'hFF], 8'h22);

    clear_img(); put(8'hE9); put(8'hEA); put(8'h05); put(8'h06); put(8'hEF); put(8'h88);
    put(8'hE6); put(8'hEE); put(8'h07); put(8'h00); put(8'h01); put(8'h90);
    run(1'b0);
    check("R12 pop and nops", mem[8'hFE], 8'h07);
    check("R12 flip carry", mem[8'hFD], 8'h00);
    check("R12 base kept", mem[8'hFF], 8'h05);

    clear_img(); put(8'hE9); put(8'h40); put(8'hB4);
    run(1'b0);
    check("R8 shift carry in", mem[8'hFF], 8'h81);

    for (int n = 0; n < 60; n++) begin
      logic [7:0] a, b, o;
      logic c;
      logic [8:0] e;
      a = mkv($urandom);
      b = mkv($urandom);
      c = $urandom % 2;
      o = ops[$urandom % 15];
      if (n < 15) o = ops[n];
      e = model(o, a, b, c);
      clear_img(); put(c ? 8'hE9 : 8'hE8); put(b); put(a); put(o);
      put(8'h00); put(8'h01); put(8'h90);
      run(1'b0);
      if (o[7:4] == 4'hB) begin
        check({tag(o), " unary result"}, mem[8'hFE], e[7:0]);
        check({tag(o), " unary flag"}, mem[8'hFD], {7'd0, e[8]});
      end else begin
        check({tag(o), " binary result"}, mem[8'hFF], e[7:0]);
        check({tag(o), " binary flag"}, mem[8'hFE], {7'd0, e[8]});
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule